// File: doc/BRIEF.md
# Priority Interrupt Claim Arbiter

This block is the decision core of a platform interrupt controller. It keeps a pending bit and a claimed bit for every interrupt source, a 3-bit priority for every source, an enable mask and a threshold for every target context, and from that state drives one registered notify line per context. A context asks for work with a claim request and receives the ID of the most urgent source it may take, and later hands the ID back through a completion to release it.

Sources are level-sensitive wires. A change in a source's level is copied into its pending bit. A claim moves the winning source from pending to claimed, and a claimed source is hidden from every context until it is completed. Notify lines are recomputed every cycle from the current state, so every kind of state change (level, claim, completion, priority, enable, threshold) is reflected one cycle later. A pending source cannot be lost when it is enabled late, and a claimed source cannot keep a context interrupted.

Claim requests carry data out of the block but apply no back-pressure: the block accepts a request in every cycle in which `claim_valid_i` is high, and answers in the next cycle with a one-cycle pulse on `claim_rsp_valid_o`. The requester must take the response in that cycle. Configuration writes and completions are accepted on every cycle in which their strobe is high.

Top module: `plic_core`

## Requirements
- R1: After reset every notify line is low, and a claim from any context returns ID 0, because all pending, claimed, enable, priority and threshold state is zero.
- R2: A source is eligible for a context only while it is pending, not claimed, and its bit in that context's enable mask (bit n of the mask is source n) is set. Enabling a source that is already pending raises notify with no new level change.
- R3: A context's notify line is high exactly when some eligible source has a priority strictly greater than that context's threshold. A priority equal to the threshold does not notify.
- R4: A claim returns the ID of the eligible source with the highest priority above the context's threshold, or 0 when none qualifies. The response appears on the cycle after the request. Source 0 is reserved: it is never pending, writes to its priority are ignored, and it is never returned.
- R5: Among eligible sources of equal top priority, the claim returns the lowest ID.
- R6: A successful claim clears the source's pending bit and sets its claimed bit at once. A claimed source is eligible for no context until it is completed.
- R7: A completion whose ID is below NUM_SOURCES clears that source's claimed bit. A completion with an ID of NUM_SOURCES or more changes nothing.
- R8: A priority write stores only the low 3 bits of the written value.
- R9: A threshold write takes effect only when the value is at most NUM_LEVELS. A larger value is dropped and the old threshold is kept.
- R10: Notify lines are registered: a state change made at one clock edge shows on notify at the following edge, and this holds for level changes, claims, completions and configuration writes.
- R11: A rising source level sets its pending bit, and a falling level clears it. A level that is held high does not set the pending bit again after a claim.
- R12: When a source's level falls in the same cycle in which it is claimed, the claim still returns that source, and the claim's clearing of the pending bit wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| src_level_i | input | NUM_SOURCES | Level of each source; bit 0 is unused |
| prio_wr_i | input | 1 | Priority write strobe |
| prio_wr_id_i | input | IDW | Source ID for the priority write |
| prio_wr_data_i | input | 8 | Priority value; low 3 bits are stored |
| en_wr_i | input | 1 | Enable mask write strobe |
| en_wr_ctx_i | input | CTXW | Context whose mask is written |
| en_wr_data_i | input | NUM_SOURCES | New enable mask, bit n for source n |
| thr_wr_i | input | 1 | Threshold write strobe |
| thr_wr_ctx_i | input | CTXW | Context whose threshold is written |
| thr_wr_data_i | input | 8 | New threshold value |
| claim_valid_i | input | 1 | Claim request, accepted every cycle it is high |
| claim_ctx_i | input | CTXW | Context making the claim |
| claim_rsp_valid_o | output | 1 | One-cycle pulse carrying a claim answer |
| claim_rsp_id_o | output | IDW | Claimed source ID, 0 for none |
| cmpl_valid_i | input | 1 | Completion strobe |
| cmpl_id_i | input | IDW | Source ID being released |
| notify_o | output | NUM_CONTEXTS | Registered interrupt notify per context |

## Verification
On every cycle the assertions check that a claimed bit only rises through a claim answer naming that source, that a claim answer leaves its source claimed and not pending, that out-of-range completions never release anything, that oversized thresholds leave the threshold unchanged, and that a priority write stores exactly its low three bits. What only the bench's scenarios can show is the arbitration itself: which ID wins under mixed priorities and ties, the strict comparison with the threshold, the one-cycle notify latency, masking across contexts, late enabling, and the order of a claim against a falling level.

// File: rtl/plic_core_pkg.sv
`timescale 1ns/1ps
package plic_core_pkg;
  localparam int PRIO_W = 3;
  localparam int WDATA_W = 8;
  typedef logic [PRIO_W-1:0] prio_t;
endpackage

// File: rtl/plic_src_state.sv
`timescale 1ns/1ps
module plic_src_state #(
  parameter int NUM_SOURCES = 16
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NUM_SOURCES-1:0] level_i,
  input  logic [NUM_SOURCES-1:0] take_i,
  input  logic [NUM_SOURCES-1:0] release_i,
  output logic [NUM_SOURCES-1:0] pending_o,
  output logic [NUM_SOURCES-1:0] claimed_o
);

  for (genvar i = 0; i < NUM_SOURCES; i++) begin : g_src
    if (i == 0) begin : g_reserved
      logic unused_src0;
      assign unused_src0 = level_i[0] ^ take_i[0] ^ release_i[0];
      assign pending_o[0] = 1'b0;
      assign claimed_o[0] = 1'b0;
    end else begin : g_live
      logic lvl_q;
      logic pend_q;
      logic clm_q;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          lvl_q  <= 1'b0;
          pend_q <= 1'b0;
          clm_q  <= 1'b0;
        end else begin
          lvl_q <= level_i[i];
          if (take_i[i]) begin
            pend_q <= 1'b0;
          end else if (level_i[i] != lvl_q) begin
            pend_q <= level_i[i];
          end
          if (take_i[i]) begin
            clm_q <= 1'b1;
          end else if (release_i[i]) begin
            clm_q <= 1'b0;
          end
        end
      end

      assign pending_o[i] = pend_q;
      assign claimed_o[i] = clm_q;
    end
  end

endmodule

// File: rtl/plic_cfg_regs.sv
`timescale 1ns/1ps
module plic_cfg_regs
  import plic_core_pkg::*;
#(
  parameter int NUM_SOURCES  = 16,
  parameter int NUM_CONTEXTS = 2,
  parameter int NUM_LEVELS   = 7,
  parameter int IDW          = 5,
  parameter int CTXW         = 1
) (
  input  logic                                     clk,
  input  logic                                     rst_n,
  input  logic                                     prio_wr_i,
  input  logic [IDW-1:0]                           prio_wr_id_i,
  input  logic [WDATA_W-1:0]                       prio_wr_data_i,
  input  logic                                     en_wr_i,
  input  logic [CTXW-1:0]                          en_wr_ctx_i,
  input  logic [NUM_SOURCES-1:0]                   en_wr_data_i,
  input  logic                                     thr_wr_i,
  input  logic [CTXW-1:0]                          thr_wr_ctx_i,
  input  logic [WDATA_W-1:0]                       thr_wr_data_i,
  output logic [NUM_SOURCES-1:0][PRIO_W-1:0]       prio_o,
  output logic [NUM_CONTEXTS-1:0][NUM_SOURCES-1:0] enable_o,
  output logic [NUM_CONTEXTS-1:0][PRIO_W-1:0]      thr_o
);

  logic thr_ok;
  assign thr_ok = int'(thr_wr_data_i) <= NUM_LEVELS;

  for (genvar i = 0; i < NUM_SOURCES; i++) begin : g_prio
    if (i == 0) begin : g_reserved
      assign prio_o[0] = '0;
    end else begin : g_live
      prio_t prio_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          prio_q <= '0;
        end else if (prio_wr_i && int'(prio_wr_id_i) == i) begin
          prio_q <= prio_wr_data_i[PRIO_W-1:0];
        end
      end
      assign prio_o[i] = prio_q;
    end
  end

  for (genvar c = 0; c < NUM_CONTEXTS; c++) begin : g_ctx
    logic [NUM_SOURCES-1:0] en_q;
    prio_t                  thr_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        en_q  <= '0;
        thr_q <= '0;
      end else begin
        if (en_wr_i && int'(en_wr_ctx_i) == c) begin
          en_q <= en_wr_data_i & ~NUM_SOURCES'(1);
        end
        if (thr_wr_i && thr_ok && int'(thr_wr_ctx_i) == c) begin
          thr_q <= thr_wr_data_i[PRIO_W-1:0];
        end
      end
    end

    assign enable_o[c] = en_q;
    assign thr_o[c]    = thr_q;
  end

endmodule

// File: rtl/plic_ctx_arb.sv
`timescale 1ns/1ps
module plic_ctx_arb
  import plic_core_pkg::*;
#(
  parameter int NUM_SOURCES = 16,
  parameter int IDW         = 5
) (
  input  logic [NUM_SOURCES-1:0]             pending_i,
  input  logic [NUM_SOURCES-1:0]             claimed_i,
  input  logic [NUM_SOURCES-1:0]             enable_i,
  input  logic [NUM_SOURCES-1:0][PRIO_W-1:0] prio_i,
  input  prio_t                              thr_i,
  output logic [IDW-1:0]                     win_id_o,
  output logic                               win_hit_o
);

  logic [NUM_SOURCES-1:0] eligible;
  assign eligible = pending_i & ~claimed_i & enable_i;

  // Ascending scan; only a strictly higher priority displaces the
  // current best, so ties resolve to the lowest ID.
  always_comb begin
    logic [IDW-1:0] best_id;
    prio_t          best_p;
    best_id = '0;
    best_p  = thr_i;
    for (int i = 1; i < NUM_SOURCES; i++) begin
      if (eligible[i] && prio_i[i] > best_p) begin
        best_id = IDW'(i);
        best_p  = prio_i[i];
      end
    end
    win_id_o  = best_id;
    win_hit_o = best_id != '0;
  end

endmodule

// File: rtl/plic_core.sv
`timescale 1ns/1ps
module plic_core
  import plic_core_pkg::*;
#(
  parameter int NUM_SOURCES  = 16,
  parameter int NUM_CONTEXTS = 2,
  parameter int NUM_LEVELS   = 7,
  localparam int IDW  = $clog2(NUM_SOURCES) + 1,
  localparam int CTXW = (NUM_CONTEXTS > 1) ? $clog2(NUM_CONTEXTS) : 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NUM_SOURCES-1:0]  src_level_i,
  input  logic                    prio_wr_i,
  input  logic [IDW-1:0]          prio_wr_id_i,
  input  logic [WDATA_W-1:0]      prio_wr_data_i,
  input  logic                    en_wr_i,
  input  logic [CTXW-1:0]         en_wr_ctx_i,
  input  logic [NUM_SOURCES-1:0]  en_wr_data_i,
  input  logic                    thr_wr_i,
  input  logic [CTXW-1:0]         thr_wr_ctx_i,
  input  logic [WDATA_W-1:0]      thr_wr_data_i,
  input  logic                    claim_valid_i,
  input  logic [CTXW-1:0]         claim_ctx_i,
  output logic                    claim_rsp_valid_o,
  output logic [IDW-1:0]          claim_rsp_id_o,
  input  logic                    cmpl_valid_i,
  input  logic [IDW-1:0]          cmpl_id_i,
  output logic [NUM_CONTEXTS-1:0] notify_o
);

  logic [NUM_SOURCES-1:0]                   pending;
  logic [NUM_SOURCES-1:0]                   claimed;
  logic [NUM_SOURCES-1:0][PRIO_W-1:0]       prio;
  logic [NUM_CONTEXTS-1:0][NUM_SOURCES-1:0] enable;
  logic [NUM_CONTEXTS-1:0][PRIO_W-1:0]      thr;
  logic [NUM_CONTEXTS-1:0][IDW-1:0]         win_id;
  logic [NUM_CONTEXTS-1:0]                  win_hit;

  logic [IDW-1:0]         sel_id;
  logic                   take;
  logic [NUM_SOURCES-1:0] take_vec;
  logic [NUM_SOURCES-1:0] release_vec;

  plic_src_state #(
    .NUM_SOURCES (NUM_SOURCES)
  ) u_src (
    .clk       (clk),
    .rst_n     (rst_n),
    .level_i   (src_level_i),
    .take_i    (take_vec),
    .release_i (release_vec),
    .pending_o (pending),
    .claimed_o (claimed)
  );

  plic_cfg_regs #(
    .NUM_SOURCES  (NUM_SOURCES),
    .NUM_CONTEXTS (NUM_CONTEXTS),
    .NUM_LEVELS   (NUM_LEVELS),
    .IDW          (IDW),
    .CTXW         (CTXW)
  ) u_cfg (
    .clk            (clk),
    .rst_n          (rst_n),
    .prio_wr_i      (prio_wr_i),
    .prio_wr_id_i   (prio_wr_id_i),
    .prio_wr_data_i (prio_wr_data_i),
    .en_wr_i        (en_wr_i),
    .en_wr_ctx_i    (en_wr_ctx_i),
    .en_wr_data_i   (en_wr_data_i),
    .thr_wr_i       (thr_wr_i),
    .thr_wr_ctx_i   (thr_wr_ctx_i),
    .thr_wr_data_i  (thr_wr_data_i),
    .prio_o         (prio),
    .enable_o       (enable),
    .thr_o          (thr)
  );

  for (genvar c = 0; c < NUM_CONTEXTS; c++) begin : g_arb
    plic_ctx_arb #(
      .NUM_SOURCES (NUM_SOURCES),
      .IDW         (IDW)
    ) u_arb (
      .pending_i (pending),
      .claimed_i (claimed),
      .enable_i  (enable[c]),
      .prio_i    (prio),
      .thr_i     (thr[c]),
      .win_id_o  (win_id[c]),
      .win_hit_o (win_hit[c])
    );
  end

  // Claim path: pick the requesting context's winner.
  always_comb begin
    sel_id = '0;
    for (int c = 0; c < NUM_CONTEXTS; c++) begin
      if (int'(claim_ctx_i) == c) begin
        sel_id = win_id[c];
      end
    end
  end

  assign take     = claim_valid_i && (sel_id != '0);
  assign take_vec = take ? (NUM_SOURCES'(1) << sel_id) : '0;

  assign release_vec = (cmpl_valid_i && int'(cmpl_id_i) < NUM_SOURCES)
                       ? (NUM_SOURCES'(1) << cmpl_id_i) : '0;

  logic                    rsp_valid_q;
  logic [IDW-1:0]          rsp_id_q;
  logic [NUM_CONTEXTS-1:0] notify_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid_q <= 1'b0;
      rsp_id_q    <= '0;
      notify_q    <= '0;
    end else begin
      rsp_valid_q <= claim_valid_i;
      rsp_id_q    <= claim_valid_i ? sel_id : '0;
      notify_q    <= win_hit;
    end
  end

  assign claim_rsp_valid_o = rsp_valid_q;
  assign claim_rsp_id_o    = rsp_id_q;
  assign notify_o          = notify_q;

endmodule

// File: rtl/plic_core_chk.sv
`timescale 1ns/1ps
module plic_core_chk
  import plic_core_pkg::*;
#(
  parameter int NUM_SOURCES  = 16,
  parameter int NUM_CONTEXTS = 2,
  parameter int NUM_LEVELS   = 7,
  parameter int IDW          = 5
) (
  input logic                               clk,
  input logic                               rst_n,
  input logic                               prio_wr_i,
  input logic [IDW-1:0]                     prio_wr_id_i,
  input logic [WDATA_W-1:0]                 prio_wr_data_i,
  input logic                               thr_wr_i,
  input logic [WDATA_W-1:0]                 thr_wr_data_i,
  input logic                               claim_valid_i,
  input logic                               claim_rsp_valid_o,
  input logic [IDW-1:0]                     claim_rsp_id_o,
  input logic                               cmpl_valid_i,
  input logic [IDW-1:0]                     cmpl_id_i,
  input logic [NUM_SOURCES-1:0]             pending,
  input logic [NUM_SOURCES-1:0]             claimed,
  input logic [NUM_SOURCES-1:0][PRIO_W-1:0] prio,
  input logic [NUM_CONTEXTS-1:0][PRIO_W-1:0] thr
);

  // R4: an answer only follows a request one cycle earlier
  p_rsp_follows_req_r4: assert property (@(posedge clk) disable iff (!rst_n)
    claim_rsp_valid_o |-> $past(claim_valid_i));

  // R6: a granted source is claimed and no longer pending
  p_claim_moves_state_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (claim_rsp_valid_o && claim_rsp_id_o != '0)
      |-> (claimed[claim_rsp_id_o] && !pending[claim_rsp_id_o]));

  // R6: a claimed bit rises only through a claim answer naming it
  for (genvar i = 1; i < NUM_SOURCES; i++) begin : g_rise
    p_claim_only_by_grant_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(claimed[i]) |-> (claim_rsp_valid_o && int'(claim_rsp_id_o) == i));
  end

  // R7: out-of-range completion releases nothing
  p_bad_cmpl_ignored_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cmpl_valid_i && int'(cmpl_id_i) >= NUM_SOURCES)
      |=> (($past(claimed) & ~claimed) == '0));

  // R8: stored priority is the low bits of the write
  p_prio_trunc_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (prio_wr_i && prio_wr_id_i != '0 && int'(prio_wr_id_i) < NUM_SOURCES)
      |=> (prio[$past(prio_wr_id_i)] == $past(prio_wr_data_i[PRIO_W-1:0])));

  // R9: oversized threshold write is dropped
  p_thr_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (thr_wr_i && int'(thr_wr_data_i) > NUM_LEVELS) |=> (thr == $past(thr)));

endmodule

bind plic_core plic_core_chk #(
  .NUM_SOURCES  (NUM_SOURCES),
  .NUM_CONTEXTS (NUM_CONTEXTS),
  .NUM_LEVELS   (NUM_LEVELS),
  .IDW          (IDW)
) u_chk (
  .clk               (clk),
  .rst_n             (rst_n),
  .prio_wr_i         (prio_wr_i),
  .prio_wr_id_i      (prio_wr_id_i),
  .prio_wr_data_i    (prio_wr_data_i),
  .thr_wr_i          (thr_wr_i),
  .thr_wr_data_i     (thr_wr_data_i),
  .claim_valid_i     (claim_valid_i),
  .claim_rsp_valid_o (claim_rsp_valid_o),
  .claim_rsp_id_o    (claim_rsp_id_o),
  .cmpl_valid_i      (cmpl_valid_i),
  .cmpl_id_i         (cmpl_id_i),
  .pending           (pending),
  .claimed           (claimed),
  .prio              (prio),
  .thr               (thr)
);

// File: tb/plic_core_test.sv
`timescale 1ns/1ps
module plic_core_test;
  localparam int NS   = 16;
  localparam int NC   = 2;
  localparam int IDW  = 5;
  localparam int CTXW = 1;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [NS-1:0]   src_level_i = '0;
  logic            prio_wr_i = 1'b0;
  logic [IDW-1:0]  prio_wr_id_i = '0;
  logic [7:0]      prio_wr_data_i = '0;
  logic            en_wr_i = 1'b0;
  logic [CTXW-1:0] en_wr_ctx_i = '0;
  logic [NS-1:0]   en_wr_data_i = '0;
  logic            thr_wr_i = 1'b0;
  logic [CTXW-1:0] thr_wr_ctx_i = '0;
  logic [7:0]      thr_wr_data_i = '0;
  logic            claim_valid_i = 1'b0;
  logic [CTXW-1:0] claim_ctx_i = '0;
  logic            claim_rsp_valid_o;
  logic [IDW-1:0]  claim_rsp_id_o;
  logic            cmpl_valid_i = 1'b0;
  logic [IDW-1:0]  cmpl_id_i = '0;
  logic [NC-1:0]   notify_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  plic_core #(.NUM_SOURCES(NS), .NUM_CONTEXTS(NC), .NUM_LEVELS(7)) uut (.*);

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    src_level_i = '0;
    rst_n = 1'b0;
    tick(2);
    rst_n = 1'b1;
    tick(1);
  endtask

  task automatic set_prio(int id, int val);
    prio_wr_i = 1'b1; prio_wr_id_i = IDW'(id); prio_wr_data_i = 8'(val);
    tick(1);
    prio_wr_i = 1'b0;
  endtask

  task automatic set_en(int ctx, logic [NS-1:0] mask);
    en_wr_i = 1'b1; en_wr_ctx_i = CTXW'(ctx); en_wr_data_i = mask;
    tick(1);
    en_wr_i = 1'b0;
  endtask

  task automatic set_thr(int ctx, int val);
    thr_wr_i = 1'b1; thr_wr_ctx_i = CTXW'(ctx); thr_wr_data_i = 8'(val);
    tick(1);
    thr_wr_i = 1'b0;
  endtask

  task automatic do_claim(int ctx, output int id);
    claim_valid_i = 1'b1; claim_ctx_i = CTXW'(ctx);
    tick(1);
    claim_valid_i = 1'b0;
    chk("R4 rsp valid", int'(claim_rsp_valid_o), 1);
    id = int'(claim_rsp_id_o);
  endtask

  task automatic complete(int id);
    cmpl_valid_i = 1'b1; cmpl_id_i = IDW'(id);
    tick(1);
    cmpl_valid_i = 1'b0;
  endtask

  task automatic t_reset();
    int id;
    do_reset();
    chk("R1 notify after reset", int'(notify_o), 0);
    chk("R1 rsp idle", int'(claim_rsp_valid_o), 0);
    do_claim(0, id);
    chk("R1 claim ctx0", id, 0);
    do_claim(1, id);
    chk("R1 claim ctx1", id, 0);
  endtask

  task automatic t_eligible();
    do_reset();
    set_prio(3, 2);
    src_level_i[3] = 1'b1;
    tick(3);
    chk("R2 disabled source no notify", int'(notify_o), 0);
    set_en(0, NS'(1) << 3);
    tick(1);
    chk("R2 late enable ctx0", int'(notify_o[0]), 1);
    chk("R2 ctx1 not enabled", int'(notify_o[1]), 0);
  endtask

  task automatic t_threshold();
    int id;
    do_reset();
    set_prio(5, 3);
    set_en(0, NS'(1) << 5);
    set_thr(0, 3);
    src_level_i[5] = 1'b1;
    tick(3);
    chk("R3 equal threshold no notify", int'(notify_o[0]), 0);
    do_claim(0, id);
    chk("R4 claim at equal threshold", id, 0);
    set_thr(0, 2);
    tick(1);
    chk("R3 above threshold notifies", int'(notify_o[0]), 1);
  endtask

  task automatic t_arbitrate();
    int id;
    do_reset();
    set_prio(2, 1); set_prio(4, 5); set_prio(6, 5); set_prio(9, 3);
    set_en(0, NS'('h0254));
    src_level_i = NS'('h0254);
    tick(3);
    chk("R3 notify with eligible", int'(notify_o[0]), 1);
    do_claim(0, id); chk("R5 tie lowest id", id, 4);
    do_claim(0, id); chk("R4 next highest", id, 6);
    do_claim(0, id); chk("R4 third", id, 9);
    do_claim(0, id); chk("R4 lowest prio", id, 2);
    do_claim(0, id); chk("R4 none left", id, 0);
    tick(1);
    chk("R10 notify drops after claims", int'(notify_o[0]), 0);
  endtask

  task automatic t_mask_complete();
    int id;
    do_reset();
    set_prio(7, 4);
    set_en(0, NS'(1) << 7);
    set_en(1, NS'(1) << 7);
    src_level_i[7] = 1'b1;
    tick(3);
    chk("R3 both ctx notify", int'(notify_o), 3);
    do_claim(0, id);
    chk("R6 claim ctx0", id, 7);
    tick(1);
    chk("R6 masked from ctx1", int'(notify_o[1]), 0);
    do_claim(1, id);
    chk("R6 ctx1 cannot claim", id, 0);
    src_level_i[7] = 1'b0; tick(1);
    src_level_i[7] = 1'b1; tick(2);
    chk("R6 pending but claimed", int'(notify_o), 0);
    complete(NS + 2);
    tick(1);
    chk("R7 big completion ignored", int'(notify_o), 0);
    complete(7);
    chk("R10 notify before latency", int'(notify_o), 0);
    tick(1);
    chk("R7 completion releases", int'(notify_o), 3);
  endtask

  task automatic t_level();
    int id;
    do_reset();
    set_prio(8, 2);
    set_en(0, NS'(1) << 8);
    src_level_i[8] = 1'b1;
    tick(3);
    do_claim(0, id);
    chk("R11 claim", id, 8);
    complete(8);
    tick(2);
    chk("R11 held level no re-pend", int'(notify_o[0]), 0);
    src_level_i[8] = 1'b0; tick(1);
    src_level_i[8] = 1'b1; tick(2);
    chk("R11 rising sets pending", int'(notify_o[0]), 1);
    src_level_i[8] = 1'b0; tick(2);
    chk("R11 falling clears pending", int'(notify_o[0]), 0);
  endtask

  task automatic t_prio_trunc();
    do_reset();
    set_prio(10, 'h0A);
    set_en(0, NS'(1) << 10);
    src_level_i[10] = 1'b1;
    set_thr(0, 2);
    tick(2);
    chk("R8 0x0A stored as 2 vs thr 2", int'(notify_o[0]), 0);
    set_thr(0, 1);
    tick(1);
    chk("R8 0x0A stored as 2 vs thr 1", int'(notify_o[0]), 1);
    set_prio(10, 'hF9);
    tick(1);
    chk("R8 0xF9 stored as 1 vs thr 1", int'(notify_o[0]), 0);
  endtask

  task automatic t_thr_drop();
    do_reset();
    set_prio(11, 5);
    set_en(0, NS'(1) << 11);
    src_level_i[11] = 1'b1;
    set_thr(0, 6);
    tick(2);
    chk("R9 thr 6 blocks", int'(notify_o[0]), 0);
    set_thr(0, 8);
    tick(1);
    chk("R9 thr 8 dropped", int'(notify_o[0]), 0);
    set_thr(0, 4);
    tick(1);
    chk("R9 thr 4 accepted", int'(notify_o[0]), 1);
    set_thr(0, 200);
    tick(1);
    chk("R9 thr 200 dropped", int'(notify_o[0]), 1);
    set_thr(0, 7);
    tick(1);
    chk("R9 thr 7 accepted", int'(notify_o[0]), 0);
  endtask

  task automatic t_latency();
    int id;
    do_reset();
    set_prio(12, 1);
    set_en(0, NS'(1) << 12);
    src_level_i[12] = 1'b1;
    tick(1);
    chk("R10 notify not yet", int'(notify_o[0]), 0);
    tick(1);
    chk("R10 notify one cycle later", int'(notify_o[0]), 1);
    do_claim(0, id);
    chk("R10 claim id", id, 12);
    chk("R10 notify holds at claim edge", int'(notify_o[0]), 1);
    tick(1);
    chk("R10 notify drops next edge", int'(notify_o[0]), 0);
  endtask

  task automatic t_race_and_src0();
    int id;
    do_reset();
    set_prio(13, 3);
    set_prio(0, 7);
    set_en(0, '1);
    src_level_i[13] = 1'b1;
    src_level_i[0] = 1'b1;
    tick(3);
    src_level_i[13] = 1'b0;
    do_claim(0, id);
    chk("R12 claim wins over falling level", id, 13);
    complete(13);
    tick(2);
    chk("R12 pending stays clear", int'(notify_o[0]), 0);
    do_claim(0, id);
    chk("R4 source 0 never returned", id, 0);
  endtask

  initial begin
    t_reset();
    t_eligible();
    t_threshold();
    t_arbitrate();
    t_mask_complete();
    t_level();
    t_prio_trunc();
    t_thr_drop();
    t_latency();
    t_race_and_src0();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #(8 * 100000);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog actual 0 expected 1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule